// File: doc/BRIEF.md
# Runtime-Partitioned SIMD Adder

This block is a two-operand adder whose carry chain can be broken at fixed candidate positions by control bits supplied at run time. With every break disabled it behaves as one full-width adder. Each enabled break splits the operands into independent lanes. Each lane wraps modulo its own width, and no carry travels from one lane into the next. The same hardware therefore serves as one wide add or as several narrower SIMD adds, and neighbouring lanes may have different widths.

Candidate breaks lie every `SEG_W` bits. Enable bit k controls the break at bit position `SEG_W*(k+1)`. With the defaults (16 bits, 4-bit segments) the candidates are bits 4, 8 and 12, controlled by enable bits 0, 1 and 2.

The block is purely combinational. A second output gives a lane-boundary mask: all ones, except a zero at each bit position where an enabled break sits. There is no state machine, no clock and no reset inside the block.

Top module: `psa_adder`

## Requirements
- R1: With `cut_en` = 3'b000, `sum` equals (`op_a` + `op_b`) mod 2^16.
- R2: With only `cut_en[1]` set (break at bit 8), `sum[15:8]` and `sum[7:0]` are the independent byte sums of the operands, each mod 2^8.
- R3: With `cut_en` = 3'b111, each of the four nibbles of `sum` is the sum of the matching operand nibbles mod 2^4.
- R4: When `cut_en[k]` is set, the segment of `sum` directly above bit `4*(k+1)` equals the sum of the operand bits of that segment mod 2^4, whatever the lower bits are. No carry crosses an enabled break.
- R5: The carry out of the top bit of every lane is discarded. For example, 0xFFFF + 0x0001 with no breaks gives 0x0000.
- R6: `cut_mask` is all ones except a zero at bit `4*(k+1)` for each set `cut_en[k]`. For example, `cut_en` = 3'b101 gives 0xEFEF, and 3'b000 gives 0xFFFF.
- R7: A disabled break passes the carry. For example, with `cut_en` = 3'b101, 0x00F0 + 0x0010 gives 0x0100, which forms a single 8-bit lane over bits 4 to 11.
- R8: The outputs follow the inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| cut_en | input | 3 | Break enables; bit k cuts the carry at bit 4*(k+1) |
| sum | output | 16 | Concatenated lane sums |
| cut_mask | output | 16 | Ones everywhere except zeros at enabled break bits |

## Verification
The adder is tried with all eight break patterns. For each pattern the operands are all zeros, all ones, equal mixed values and values that each carry out of every nibble. A bit-serial reference that clears its carry at enabled breaks separates a carry that leaks across a break from one that is wrongly blocked. Directed cases cover top-bit wraparound, the mixed-lane-width pattern where a disabled break sits between two enabled ones, and the mask output. The outputs are sampled without any clock edge after the inputs change, which shows the block has no register in its path.

// File: rtl/psa_pkg.sv
package psa_pkg;
    // Position of operand bit i inside the widened vector that carries
    // one spacer bit above every segment except the last.
    function automatic int widened_pos(input int i, input int seg_w);
        return i + (i / seg_w);
    endfunction

    // Position of the spacer that sits above segment k.
    function automatic int spacer_pos(input int k, input int seg_w);
        return (k + 1) * seg_w + k;
    endfunction
endpackage

// File: rtl/psa_widen.sv
module psa_widen
    import psa_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEG_W  = 4,
    localparam int NCUT  = DATA_W / SEG_W - 1,
    localparam int WIDE_W = DATA_W + NCUT
) (
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [NCUT-1:0]   cut_en,
    output logic [WIDE_W-1:0] wide_a,
    output logic [WIDE_W-1:0] wide_b
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_data
        assign wide_a[widened_pos(i, SEG_W)] = in_a[i];
        assign wide_b[widened_pos(i, SEG_W)] = in_b[i];
    end

    // Spacer: 0 + 0 absorbs the carry (break on); 0 + 1 forwards it (break off).
    for (genvar k = 0; k < NCUT; k++) begin : g_spacer
        assign wide_a[spacer_pos(k, SEG_W)] = 1'b0;
        assign wide_b[spacer_pos(k, SEG_W)] = ~cut_en[k];
    end
endmodule

// File: rtl/psa_strip.sv
module psa_strip
    import psa_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEG_W  = 4,
    localparam int NCUT  = DATA_W / SEG_W - 1,
    localparam int WIDE_W = DATA_W + NCUT
) (
    input  logic [WIDE_W-1:0] wide_sum,
    output logic [DATA_W-1:0] lane_sum
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_pick
        assign lane_sum[i] = wide_sum[widened_pos(i, SEG_W)];
    end
endmodule

// File: rtl/psa_cut_mask.sv
module psa_cut_mask #(
    parameter int DATA_W = 16,
    parameter int SEG_W  = 4,
    localparam int NCUT  = DATA_W / SEG_W - 1
) (
    input  logic [NCUT-1:0]   cut_en,
    output logic [DATA_W-1:0] mask
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if ((i % SEG_W) == 0 && i != 0) begin : g_cut
            assign mask[i] = ~cut_en[i / SEG_W - 1];
        end else begin : g_plain
            assign mask[i] = 1'b1;
        end
    end
endmodule

// File: rtl/psa_adder.sv
module psa_adder #(
    parameter int DATA_W = 16,
    parameter int SEG_W  = 4,
    localparam int NCUT  = DATA_W / SEG_W - 1,
    localparam int WIDE_W = DATA_W + NCUT
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [NCUT-1:0]   cut_en,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] cut_mask
);
    logic [WIDE_W-1:0] wide_a;
    logic [WIDE_W-1:0] wide_b;
    logic [WIDE_W-1:0] wide_sum;

    psa_widen #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_widen (
        .in_a   (op_a),
        .in_b   (op_b),
        .cut_en (cut_en),
        .wide_a (wide_a),
        .wide_b (wide_b)
    );

    // One carry chain; the top carry is dropped by the width (R5).
    assign wide_sum = wide_a + wide_b;

    psa_strip #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_strip (
        .wide_sum (wide_sum),
        .lane_sum (sum)
    );

    psa_cut_mask #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_mask (
        .cut_en (cut_en),
        .mask   (cut_mask)
    );

    // ---------------- assertions ----------------
    logic [DATA_W-1:0] full_ref;
    logic [SEG_W-1:0]  low_ref;
    assign full_ref = op_a + op_b;
    assign low_ref  = op_a[SEG_W-1:0] + op_b[SEG_W-1:0];

    always_comb begin
        if (cut_en == '0)
            assert_full_width_R1: assert (sum == full_ref)
                else $error("R1 full-width sum mismatch");
        assert_low_lane_R5: assert (sum[SEG_W-1:0] == low_ref)
            else $error("R5 lowest segment mismatch");
    end

    for (genvar k = 0; k < NCUT; k++) begin : g_chk
        logic [SEG_W-1:0] seg_ref;
        assign seg_ref = op_a[(k+2)*SEG_W-1:(k+1)*SEG_W]
                       + op_b[(k+2)*SEG_W-1:(k+1)*SEG_W];
        always_comb begin
            if (cut_en[k])
                assert_no_carry_cross_R4: assert (sum[(k+2)*SEG_W-1:(k+1)*SEG_W] == seg_ref)
                    else $error("R4 carry crossed enabled break %0d", k);
            assert_mask_bit_R6: assert (cut_mask[(k+1)*SEG_W] == !cut_en[k])
                else $error("R6 mask bit wrong at break %0d", k);
        end
    end
endmodule

// File: tb/tb_psa_adder.sv
`timescale 1ns/1ps
module tb_psa_adder;
    localparam int W = 16;
    localparam int NC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0]  op_a, op_b, sum, cut_mask;
    logic [NC-1:0] cut_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    psa_adder dut (
        .op_a     (op_a),
        .op_b     (op_b),
        .cut_en   (cut_en),
        .sum      (sum),
        .cut_mask (cut_mask)
    );

    // Bit-serial reference: the carry is cleared at each enabled break.
    function automatic logic [W-1:0] ref_sum(input logic [W-1:0] a,
                                             input logic [W-1:0] b,
                                             input logic [NC-1:0] en);
        logic [W-1:0] r = '0;
        logic c = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i % 4 == 0 && i != 0 && en[i/4-1]) c = 1'b0;
            r[i] = a[i] ^ b[i] ^ c;
            c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [NC-1:0] en);
        op_a = a; op_b = b; cut_en = en;
        #1;
    endtask

    localparam int NV = 5;
    localparam logic [W-1:0] VA [NV] = '{16'h0000, 16'hFFFF, 16'hABCD, 16'h1234, 16'h8888};
    localparam logic [W-1:0] VB [NV] = '{16'h0000, 16'hFFFF, 16'hABCD, 16'hEDCC, 16'h8888};

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        op_a = '0; op_b = '0; cut_en = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Idle state: zero operands give zero sum and a full mask (R1, R6)
        check("R1 idle sum", sum, 16'h0000);
        check("R6 idle mask", cut_mask, 16'hFFFF);

        // Vector table over all break patterns (R1 R2 R3 R4)
        for (int e = 0; e < 8; e++) begin
            for (int v = 0; v < NV; v++) begin
                @(negedge clk);
                apply(VA[v], VB[v], NC'(e));
                check(e == 0 ? "R1 table" : e == 2 ? "R2 table" :
                      e == 7 ? "R3 table" : "R4 table",
                      sum, ref_sum(VA[v], VB[v], NC'(e)));
            end
        end

        // Directed corners
        @(negedge clk); apply(16'hFFFF, 16'h0001, 3'b000);
        check("R5 top wrap", sum, 16'h0000);
        apply(16'h12FF, 16'h3401, 3'b010);
        check("R2 bytes", sum, 16'h4600);
        apply(16'hABCD, 16'hABCD, 3'b111);
        check("R3 nibbles", sum, 16'h468A);
        apply(16'h00F0, 16'h0010, 3'b101);
        check("R7 disabled break passes carry", sum, 16'h0100);
        apply(16'h0FFF, 16'h0001, 3'b100);
        check("R4 top nibble isolated", sum, 16'h0000);
        check("R6 mask 100", cut_mask, 16'hEFFF);
        apply(16'h0000, 16'h0000, 3'b101);
        check("R6 mask 101", cut_mask, 16'hEFEF);
        apply(16'h0000, 16'h0000, 3'b111);
        check("R6 mask 111", cut_mask, 16'hEEEF);

        // Same-cycle response: change inputs between edges (R8)
        @(negedge clk);
        op_a = 16'h0FF0; op_b = 16'h0010; cut_en = 3'b000;
        #0.5;
        check("R8 no-break same cycle", sum, 16'h1000);
        cut_en = 3'b011;
        #0.5;
        check("R8 breaks same cycle", sum, 16'h0F00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule